// File: doc/BRIEF.md
# Staged Address/Data Register Memory Access Unit

This block is a four-word memory in which every access passes through two holding registers: an address register that captures the location, and a data register that receives words read out. Writes never take data from the requester directly; they copy the contents of an accumulator register, which has its own load port. A controller raises either a fetch request or a store request together with an address.

An accepted request runs as a fixed sequence of one-clock steps: the address register is loaded, its value is decoded into one-hot select lines, the selected cell is read into the data register or overwritten from the accumulator, and a completion pulse is given. While the sequence runs the unit reports busy and ignores further requests and accumulator loads. The unit is meant to sit under a simple control sequencer, which waits for the completion pulse before it issues the next access.

Reset is asynchronous and active-low. Its release is synchronised inside the block, so internal logic leaves reset on the second rising clock edge after the reset pin goes high.

Top module: `memstage_unit`

## Requirements
- R1: While `rst_n` is low, and for two rising clock edges after it goes high, the address register, data register, accumulator and all cells are zero, `busy`, `done` and `sel_o` are low, and the unit is idle.
- R2: A request sampled at a rising edge while idle makes `busy` high for exactly four cycles starting after that edge; `done` is high only in the fourth of them, for one cycle.
- R3: The address register (`mar_q`, 2 bits, addresses 0 to 3) takes `req_addr` at the accepting edge and holds it until the next accepted request.
- R4: `sel_o` is zero except in the third busy cycle, when exactly bit n is set, n being the address register value (bit 0 for 00, bit 1 for 01, bit 2 for 10, bit 3 for 11).
- R5: A fetch copies the addressed 16-bit cell into `mdr_q`, visible in the `done` cycle; `mdr_q` changes in no other cycle.
- R6: A fetch leaves every cell unchanged, so repeated fetches of one address return the same word.
- R7: A store replaces the addressed cell with the accumulator value; the other three cells and `mdr_q` are unchanged.
- R8: Fetch and store requests raised while `busy` is high are ignored.
- R9: `acc_load` updates `acc_q` from `acc_in` only at an edge where the unit is idle; while busy it is ignored and `acc_q` holds.
- R10: If `req_fetch` and `req_store` are both high at an accepting edge, a fetch is performed and no cell is written.
- R11: If `acc_load` and `req_store` are both accepted at the same edge, the store writes the newly loaded accumulator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| req_fetch | input | 1 | Request a read of the addressed cell into the data register |
| req_store | input | 1 | Request a write of the accumulator into the addressed cell |
| req_addr | input | 2 | Cell address for the request |
| acc_load | input | 1 | Load the accumulator from `acc_in` (idle only) |
| acc_in | input | 16 | Accumulator load value |
| busy | output | 1 | An access sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| mar_q | output | 2 | Address register contents |
| sel_o | output | 4 | One-hot cell select lines |
| mdr_q | output | 16 | Data register contents |
| acc_q | output | 16 | Accumulator contents |

## Verification
The bench builds the unit with its default widths: a 2-bit address and 16-bit words. With these values all four select lines and every cell can be reached within a short run, so each address is stored to and fetched back with distinct full-width patterns. Because each access takes only four cycles, a run can also cover the timing corners: requests and accumulator loads raised in the middle of a sequence, simultaneous fetch and store, an accumulator load in the same cycle as a store, and a reset asserted while an access is in flight.

// File: rtl/memstage_pkg.sv
package memstage_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LOAD_MAR = 3'd1,
    ST_DECODE   = 3'd2,
    ST_ACCESS   = 3'd3,
    ST_DONE     = 3'd4
  } seq_state_e;

  typedef enum logic {
    OP_FETCH = 1'b0,
    OP_STORE = 1'b1
  } mem_op_e;

endpackage

// File: rtl/memstage_rst_sync.sv
module memstage_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/memstage_decoder.sv
module memstage_decoder #(
  parameter int ADDR_W = 2,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic [DEPTH-1:0]  sel
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    assign sel[i] = en && (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/memstage_cells.sv
module memstage_cells #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEPTH-1:0]  sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic              cell_en;
    logic [DATA_W-1:0] cell_q;

    assign cell_en = wr_en && sel[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (cell_en) begin
        cell_q <= wr_data;
      end
    end

    assign word_w[i] = cell_q;
  end

  // One-hot select: OR of the gated words is the selected word.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_data = rd_data | (word_w[i] & {DATA_W{sel[i]}});
    end
  end

endmodule

// File: rtl/memstage_seq.sv
module memstage_seq
  import memstage_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fetch,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DEPTH-1:0]  dec_sel,
  output logic              dec_en,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DEPTH-1:0]  sel_q,
  output logic              idle,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic              mdr_cap
);

  seq_state_e        state_q, state_d;
  mem_op_e           op_q, op_d;
  logic [ADDR_W-1:0] mar_d;
  logic [DEPTH-1:0]  sel_d;
  logic              accept;
  logic              sel_en;

  assign accept = (state_q == ST_IDLE) && (req_fetch || req_store);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_fetch || req_store) state_d = ST_LOAD_MAR;
      ST_LOAD_MAR: state_d = ST_DECODE;
      ST_DECODE:   state_d = ST_ACCESS;
      ST_ACCESS:   state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Fetch wins when both requests arrive together.
  always_comb begin
    mar_d  = req_addr;
    op_d   = req_fetch ? OP_FETCH : OP_STORE;
    sel_en = (state_q == ST_DECODE) || (state_q == ST_ACCESS);
    sel_d  = (state_q == ST_DECODE) ? dec_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      op_q  <= OP_FETCH;
    end else if (accept) begin
      mar_q <= mar_d;
      op_q  <= op_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign dec_en  = (state_q == ST_DECODE);
  assign idle    = (state_q == ST_IDLE);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_DONE);
  assign wr_en   = (state_q == ST_ACCESS) && (op_q == OP_STORE);
  assign mdr_cap = (state_q == ST_ACCESS) && (op_q == OP_FETCH);

endmodule

// File: rtl/memstage_unit.sv
module memstage_unit #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 16,
  parameter int RST_STAGES = 2,
  localparam int DEPTH     = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fetch,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              acc_load,
  input  logic [DATA_W-1:0] acc_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DEPTH-1:0]  sel_o,
  output logic [DATA_W-1:0] mdr_q,
  output logic [DATA_W-1:0] acc_q
);

  logic              rst_int_n;
  logic              dec_en;
  logic [DEPTH-1:0]  dec_sel;
  logic [DEPTH-1:0]  sel_q;
  logic              idle;
  logic              wr_en;
  logic              mdr_cap;
  logic [DATA_W-1:0] rd_data;
  logic              acc_en;

  memstage_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  memstage_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_fetch (req_fetch),
    .req_store (req_store),
    .req_addr  (req_addr),
    .dec_sel   (dec_sel),
    .dec_en    (dec_en),
    .mar_q     (mar_q),
    .sel_q     (sel_q),
    .idle      (idle),
    .busy      (busy),
    .done      (done),
    .wr_en     (wr_en),
    .mdr_cap   (mdr_cap)
  );

  memstage_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .addr (mar_q),
    .en   (dec_en),
    .sel  (dec_sel)
  );

  memstage_cells #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel     (sel_q),
    .wr_en   (wr_en),
    .wr_data (acc_q),
    .rd_data (rd_data)
  );

  assign acc_en = acc_load && idle;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mdr_q <= '0;
    end else if (mdr_cap) begin
      mdr_q <= rd_data;
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/memstage_chk.sv
module memstage_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mar_q,
  input logic [DEPTH-1:0]  sel_o,
  input logic [DATA_W-1:0] mdr_q,
  input logic [DATA_W-1:0] acc_q
);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ##3 done);

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  // R4
  sel_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != '0) |-> (busy && !done && sel_o == (DEPTH'(1) << mar_q)));

  // R3
  mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mar_q));

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(acc_q));

  // R5
  mdr_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(mdr_q));

endmodule

bind memstage_unit memstage_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .mar_q (mar_q),
  .sel_o (sel_o),
  .mdr_q (mdr_q),
  .acc_q (acc_q)
);

// File: tb/memstage_unit_tb_top.sv
module memstage_unit_tb_top;

  localparam int AW = 2;
  localparam int DW = 16;
  localparam int NCELL = 4;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_fetch;
  logic          req_store;
  logic [AW-1:0] req_addr;
  logic          acc_load;
  logic [DW-1:0] acc_in;
  logic          busy;
  logic          done;
  logic [AW-1:0] mar_q;
  logic [NCELL-1:0] sel_o;
  logic [DW-1:0] mdr_q;
  logic [DW-1:0] acc_q;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  memstage_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fetch (req_fetch),
    .req_store (req_store),
    .req_addr  (req_addr),
    .acc_load  (acc_load),
    .acc_in    (acc_in),
    .busy      (busy),
    .done      (done),
    .mar_q     (mar_q),
    .sel_o     (sel_o),
    .mdr_q     (mdr_q),
    .acc_q     (acc_q)
  );

  // Behavioural reference model
  int m_rcnt;
  int m_phase;
  int m_mar;
  bit m_store;
  int m_mdr;
  int m_acc;
  int m_mem [NCELL];

  task automatic model_clear();
    m_phase = 0; m_mar = 0; m_store = 0; m_mdr = 0; m_acc = 0;
    for (int i = 0; i < NCELL; i++) m_mem[i] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rcnt = 0;
      model_clear();
    end else if (m_rcnt < 2) begin
      m_rcnt++;
      model_clear();
    end else begin
      case (m_phase)
        0: begin
          if (acc_load) m_acc = int'(acc_in);
          if (req_fetch || req_store) begin
            m_mar   = int'(req_addr);
            m_store = !req_fetch;
            m_phase = 1;
          end
        end
        1, 2: m_phase++;
        3: begin
          if (m_store) m_mem[m_mar] = m_acc;
          else         m_mdr = m_mem[m_mar];
          m_phase = 4;
        end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (running) begin
      check("R2 busy", int'(busy), int'(m_phase != 0));
      check("R2 done", int'(done), int'(m_phase == 4));
      check("R3 mar",  int'(mar_q), m_mar);
      check("R4 sel",  int'(sel_o), (m_phase == 3) ? (1 << m_mar) : 0);
      check("R5 mdr",  int'(mdr_q), m_mdr);
      check("R9 acc",  int'(acc_q), m_acc);
    end
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("[TB] FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic idle_inputs();
    req_fetch = 0; req_store = 0; req_addr = '0; acc_load = 0; acc_in = '0;
  endtask

  task automatic load_acc(input logic [DW-1:0] v);
    @(negedge clk);
    acc_load = 1; acc_in = v;
    @(negedge clk);
    acc_load = 0;
  endtask

  // Issue a request and wait until the sequence returns to idle.
  task automatic run_op(input bit fe, input bit st, input int addr);
    @(negedge clk);
    req_fetch = fe; req_store = st; req_addr = AW'(addr);
    @(negedge clk);
    req_fetch = 0; req_store = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic fetch_expect(input int addr, input int exp, input string tag);
    run_op(1, 0, addr);
    check(tag, int'(mdr_q), exp);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    running = 1'b1;
    // R1: reset state
    check("R1 reset mar", int'(mar_q), 0);
    check("R1 reset mdr", int'(mdr_q), 0);
    check("R1 reset acc", int'(acc_q), 0);
    check("R1 reset busy", int'(busy), 0);
    @(posedge clk); #2 rst_n = 1;
    // R1: requests during synchronised release are not taken
    @(negedge clk);
    req_fetch = 1; req_addr = 2'd1;
    @(negedge clk);
    req_fetch = 0;
    check("R1 release busy", int'(busy), 0);
    repeat (2) @(negedge clk);

    // R1 cells zero after reset, R4 all select lines
    for (int a = 0; a < NCELL; a++) fetch_expect(a, 0, "R1 cell after reset");

    // R7 store distinct words to every cell
    for (int a = 0; a < NCELL; a++) begin
      load_acc(DW'(16'hA500 + a * 16'h1111));
      run_op(0, 1, a);
    end
    check("R7 mdr kept by store", int'(mdr_q), 0);
    for (int a = 0; a < NCELL; a++)
      fetch_expect(a, 16'hA500 + a * 16'h1111, "R5 R7 fetch stored word");

    // R6 repeated fetch
    fetch_expect(2, 16'hC722, "R6 first fetch");
    fetch_expect(2, 16'hC722, "R6 second fetch");

    // R7 overwrite one cell, neighbours unchanged
    load_acc(16'hFFFF);
    run_op(0, 1, 3);
    fetch_expect(3, 16'hFFFF, "R7 overwritten");
    fetch_expect(2, 16'hC722, "R7 neighbour kept");

    // R8 store request while busy is ignored; R9 acc load while busy ignored
    load_acc(16'h0F0F);
    @(negedge clk);
    req_fetch = 1; req_addr = 2'd0;
    @(negedge clk);
    req_fetch = 0;
    req_store = 1; req_addr = 2'd1;
    acc_load = 1; acc_in = 16'h1234;
    @(negedge clk);
    req_store = 0; acc_load = 0;
    check("R9 acc held while busy", int'(acc_q), 16'h0F0F);
    repeat (3) @(negedge clk);
    check("R8 fetch result", int'(mdr_q), 16'hA500);
    check("R8 idle after", int'(busy), 0);
    fetch_expect(1, 16'hB611, "R8 cell 1 untouched");

    // R10 fetch wins over store
    load_acc(16'h5555);
    run_op(1, 1, 0);
    check("R10 mdr from fetch", int'(mdr_q), 16'hA500);
    fetch_expect(0, 16'hA500, "R10 no write");

    // R11 acc load with store in same edge
    @(negedge clk);
    acc_load = 1; acc_in = 16'h7E57;
    req_store = 1; req_addr = 2'd2;
    @(negedge clk);
    acc_load = 0; req_store = 0;
    repeat (4) @(negedge clk);
    check("R11 acc", int'(acc_q), 16'h7E57);
    fetch_expect(2, 16'h7E57, "R11 new value stored");

    // R1 async reset during an access
    @(negedge clk);
    req_store = 1; req_addr = 2'd3;
    @(negedge clk);
    req_store = 0;
    @(posedge clk); #2 rst_n = 0;
    @(negedge clk);
    check("R1 async busy", int'(busy), 0);
    check("R1 async acc", int'(acc_q), 0);
    @(posedge clk); #2 rst_n = 1;
    repeat (3) @(negedge clk);
    fetch_expect(3, 0, "R1 cell cleared");
    fetch_expect(2, 0, "R1 cell cleared");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule